// File: doc/BRIEF.md
# Fast Processor Reset and A20 Gate Register

This block is a single byte-wide system control register. Software uses it to ask for a quick reset of the processor, to gate address line 20, to set a lock that guards the power-on password, and to read whether the watchdog has expired. The watchdog and the keyboard controller sit outside the block. Each of them supplies one input bit.

The reset request starts on the edge of the value, not on its level. A write that raises the reset bit from 0 to 1 starts a timed sequence. The sequence first waits a fixed number of clock cycles and then drives a short pulse to the processor. The reset bit keeps reading 1 after the sequence ends, so start-up code can tell a warm restart from a cold one. The lock bit can only be set by software. Only the power-on reset clears it; the ordinary system reset leaves it alone.

Read layout, bit 7 down to 0: three reserved bits that read 0, then watchdog status, then lock, then a reserved bit that reads 0, then the A20 gate bit, then the reset bit.

Top module: `alt_reset_a20_ctl`

## Requirements
- R1: After a power-on reset, rd_data reads 0 apart from bit 4, and a20_out, cpu_rst_pulse and pw_lock are all 0.
- R2: rd_data bit 4 follows wdog_expired. Bits 7, 6, 5 and 2 always read 0, whatever value was written to them.
- R3: A write stores wr_data bit 1 as the A20 gate bit, which reads back at rd_data bit 1. a20_out is the OR of the gate bit and kbd_a20, so it is 0 only when both are 0.
- R4: Suppose no sequence is running and the reset bit reads 0. A write with wr_data bit 0 set then makes rd_data bit 0 read 1. After DELAY_CYC clock cycles, cpu_rst_pulse goes high and stays high for exactly PULSE_CYC cycles. The defaults are 1700 and 28 cycles. With a 4 ns clock this gives at least 6.72 µs of delay and a pulse between 100 and 125 ns wide.
- R5: Once the sequence ends, the reset bit keeps reading 1. A write with bit 0 clear sets it back to 0. A write with bit 0 set while the bit already reads 1 produces no pulse.
- R6: While a sequence is running, the bit 0 value of any write is ignored. The reset bit keeps reading 1 and the sequence does not restart, but the other writable bits still take the written value.
- R7: System reset (sys_rst_n low) clears the reset bit and the A20 gate bit, stops any running sequence without a pulse, and leaves the lock bit unchanged.
- R8: Writing 1 to bit 3 sets the lock bit, which reads back at rd_data bit 3 and drives pw_lock. Writing 0 to bit 3 has no effect. Only por_n low clears the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; clears all state |
| sys_rst_n | input | 1 | System reset, active low, synchronous; keeps the lock |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register read value |
| kbd_a20 | input | 1 | A20 enable from the keyboard controller |
| wdog_expired | input | 1 | Watchdog timeout status |
| a20_out | output | 1 | Gated address line 20 enable |
| cpu_rst_pulse | output | 1 | Processor reset pulse |
| pw_lock | output | 1 | Password area lock |

## Verification
The bench measures the delay and the width of the pulse in cycles. A counter that is off by one would show up as a wrong number for R4. It writes 0, and then 1 again, to bit 0 while a sequence is running. A design that restarts the sequence or lets the bit drop would give a second pulse, or a read of 0, for R6. It also writes 1 over a reset bit that is already 1. A design that triggers on the level instead of the edge would pulse again there. Finally, it applies a system reset in the middle of the delay. A design that clears the lock, or that lets the pending pulse fire after the reset, fails R7 and R8.

// File: rtl/alt_reset_a20_ctl.sv
module alt_reset_a20_ctl #(
  parameter int DELAY_CYC = 1700,
  parameter int PULSE_CYC = 28
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       sys_rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       kbd_a20,
  input  logic       wdog_expired,
  output logic       a20_out,
  output logic       cpu_rst_pulse,
  output logic       pw_lock
);

  localparam int CW = $clog2(DELAY_CYC + PULSE_CYC);
  localparam logic [CW-1:0] PULSE_ON = CW'(DELAY_CYC);
  localparam logic [CW-1:0] SEQ_LAST = CW'(DELAY_CYC + PULSE_CYC - 1);

  logic          hot_bit, gate_bit, lock_bit, busy;
  logic [CW-1:0] age;
  logic          start;

  assign start = wr_en && wr_data[0] && !hot_bit && !busy;

  always_ff @(posedge clk) begin
    if (!por_n) begin
      hot_bit  <= 1'b0;
      gate_bit <= 1'b0;
      lock_bit <= 1'b0;
      busy     <= 1'b0;
      age      <= '0;
    end else if (!sys_rst_n) begin
      hot_bit  <= 1'b0;
      gate_bit <= 1'b0;
      busy     <= 1'b0;
      age      <= '0;
    end else begin
      if (wr_en) begin
        gate_bit <= wr_data[1];
        if (wr_data[3]) lock_bit <= 1'b1;
        if (!busy) hot_bit <= wr_data[0];
      end
      if (start) begin
        busy <= 1'b1;
        age  <= '0;
      end else if (busy) begin
        age <= age + 1'b1;
        if (age == SEQ_LAST) busy <= 1'b0;
      end
    end
  end

  assign cpu_rst_pulse = busy && (age >= PULSE_ON);
  assign a20_out       = gate_bit | kbd_a20;
  assign pw_lock       = lock_bit;
  assign rd_data       = {3'b000, wdog_expired, lock_bit, 1'b0, gate_bit, hot_bit};

  assert_pulse_needs_bit_R4: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    cpu_rst_pulse |-> hot_bit);

  assert_seq_from_write_R4: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    $rose(busy) |-> $past(wr_en && wr_data[0] && !hot_bit));

  assert_pulse_ends_seq_R4: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    $fell(cpu_rst_pulse) |-> !busy);

  assert_bit_held_in_seq_R6: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    ($past(busy) && busy) |-> $stable(hot_bit));

  assert_sysrst_clears_R7: assert property (@(posedge clk) disable iff (!por_n)
    $past(!sys_rst_n) |-> (rd_data[1:0] == 2'b00 && !cpu_rst_pulse));

  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!por_n)
    $past(lock_bit) |-> lock_bit);

endmodule

// File: tb/test_alt_reset_a20_ctl.sv
module test_alt_reset_a20_ctl;
  localparam int D = 1700;
  localparam int P = 28;

  logic clk = 1'b0;
  logic por_n, sys_rst_n, wr_en, kbd_a20, wdog_expired;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic a20_out, cpu_rst_pulse, pw_lock;

  always #2 clk = ~clk;

  alt_reset_a20_ctl #(.DELAY_CYC(D), .PULSE_CYC(P)) i_alt_reset_a20_ctl (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .kbd_a20(kbd_a20), .wdog_expired(wdog_expired),
    .a20_out(a20_out), .cpu_rst_pulse(cpu_rst_pulse), .pw_lock(pw_lock));

  int n_chk = 0, n_fail = 0;
  bit chk_on = 0, done = 0;
  int m_gate = 0, m_hot = 0, m_lock = 0, m_age = -1, nxt = -1;
  int pulses_seen = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (!por_n) begin
      m_gate = 0; m_hot = 0; m_lock = 0; m_age = -1;
    end else if (!sys_rst_n) begin
      m_gate = 0; m_hot = 0; m_age = -1;
    end else begin
      nxt = m_age;
      if (m_age >= 0) nxt = (m_age + 1 >= D + P) ? -1 : m_age + 1;
      if (wr_en) begin
        m_gate = int'(wr_data[1]);
        if (wr_data[3]) m_lock = 1;
        if (m_age < 0) begin
          if (wr_data[0] && m_hot == 0) nxt = 0;
          m_hot = int'(wr_data[0]);
        end
      end
      m_age = nxt;
    end
  end

  always @(posedge clk) if (cpu_rst_pulse) pulses_seen++;

  always @(negedge clk) begin
    #1;
    if (chk_on) begin
      chk("R5 rd bit0", int'(rd_data[0]), m_hot);
      chk("R3 rd bit1", int'(rd_data[1]), m_gate);
      chk("R8 rd bit3", int'(rd_data[3]), m_lock);
      chk("R2 rd bit4", int'(rd_data[4]), int'(wdog_expired));
      chk("R2 reserved", int'({rd_data[7:5], rd_data[2]}), 0);
      chk("R3 a20_out", int'(a20_out), (m_gate != 0 || kbd_a20) ? 1 : 0);
      chk("R4 pulse", int'(cpu_rst_pulse), (m_age >= D) ? 1 : 0);
      chk("R8 pw_lock", int'(pw_lock), m_lock);
    end
  end

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n, base;
    por_n = 0; sys_rst_n = 0; wr_en = 0; wr_data = 0; kbd_a20 = 0; wdog_expired = 0;
    repeat (4) @(negedge clk);
    por_n = 1; sys_rst_n = 1;
    @(negedge clk); #1;
    chk("R1 rd_data", int'(rd_data), 0);
    chk("R1 a20_out", int'(a20_out), 0);
    chk("R1 pulse", int'(cpu_rst_pulse), 0);
    chk("R1 lock", int'(pw_lock), 0);
    chk_on = 1;
    @(negedge clk);

    wr(8'h02); repeat (2) @(negedge clk);
    kbd_a20 = 1; wr(8'h00); repeat (2) @(negedge clk);
    kbd_a20 = 0; @(negedge clk);
    wdog_expired = 1; wr(8'hE4); repeat (3) @(negedge clk);
    wdog_expired = 0; @(negedge clk);

    wr(8'hFF); repeat (10) @(negedge clk);
    wr(8'h00); #1;
    chk("R6 bit0 held", int'(rd_data[0]), 1);
    chk("R6 lock kept", int'(rd_data[3]), 1);
    chk("R6 gate written", int'(rd_data[1]), 0);
    wr(8'h01); repeat (2000) @(negedge clk);
    chk("R6 single pulse", pulses_seen, P);

    base = pulses_seen;
    wr(8'h01); repeat (50) @(negedge clk);
    chk("R5 no level retrigger", pulses_seen - base, 0);
    chk("R5 bit stays", int'(rd_data[0]), 1);
    wr(8'h00); #1;
    chk("R5 cleared by write", int'(rd_data[0]), 0);
    @(negedge clk);

    wr(8'h01);
    n = 0;
    while (!cpu_rst_pulse && n < 5000) begin @(negedge clk); n++; end
    chk("R4 delay cycles", n, D);
    n = 0;
    while (cpu_rst_pulse && n < 5000) begin @(negedge clk); n++; end
    chk("R4 pulse cycles", n, P);
    repeat (5) @(negedge clk);
    wr(8'h00); wr(8'h03); repeat (100) @(negedge clk);
    base = pulses_seen;
    sys_rst_n = 0; repeat (2) @(negedge clk);
    sys_rst_n = 1; #1;
    chk("R7 bits cleared", int'(rd_data[1:0]), 0);
    chk("R7 lock kept", int'(pw_lock), 1);
    repeat (2000) @(negedge clk);
    chk("R7 no pulse", pulses_seen - base, 0);

    por_n = 0; repeat (2) @(negedge clk);
    por_n = 1; #1;
    chk("R8 lock cleared by por", int'(pw_lock), 0);
    @(negedge clk);
    wr(8'h08); repeat (2) @(negedge clk);
    finish_run();
  end
endmodule